// File: doc/BRIEF.md
# Stereo Sample Stream to Serial Frame Formatter

This block takes two-channel audio arriving as a packetised stream and emits it as a clocked serial bit stream. Each input beat carries one 24-bit sample, a channel tag, the validity, user and channel-status bits for that sample, and start/end-of-packet marks. The marks belong to the channel named on the beat, so the two channels may arrive interleaved in any order. Each channel has its own FIFO of 2^LOG_DEPTH entries. The serial side produces frames of 64 clocks. Word select is high for the first half of a frame and low for the second half.

Each 32-clock half carries one sample word. The sample bits come first, MSB first. Then follow the validity, user and channel-status bits and an even parity bit generated by the block, then zero padding. A frame is filled only when both channels have a sample waiting at the frame boundary. Otherwise the frame is all zeros with the data enable low, and a sticky underflow flag is set. A pair of start/end marks on the serial side shows the frame that carries a packet boundary, such as the first or last frame of a 192-frame channel-status block. Both sides share one clock and one synchronous reset.

Top module: `stereo_serial_formatter`

## Requirements
- R1: `inReady` is low exactly when the FIFO of the channel addressed by `inChan` is full (`inChan`=0 addresses the first channel, 1 the second). A beat is written only in a cycle where `inValid` and `inReady` are both high.
- R2: The pair played in a frame is the oldest unplayed first-channel sample and the oldest unplayed second-channel sample. Arrival order is kept within each channel.
- R3: A frame counter runs over clocks 0..63. `serWs` is high on clocks 0..31 and low on 32..63. After reset the counter starts at clock 0.
- R4: Within each half, at slot position k = clock mod 32: k=0..23 carry the sample MSB first, k=24 carries V, k=25 U, k=26 C, k=27 P, and k=28..31 carry zero. The first-channel word is sent while `serWs` is high and the second-channel word while it is low.
- R5: P makes the 24 sample bits, V, U, C and P together have an even number of ones.
- R6: On clock 63 of a frame, if both FIFOs hold at least one sample (counted before that clock's write), the next frame plays a pair and `serEn` is high for all its 64 clocks. Otherwise `serEn` is low for that frame and `serData` stays 0.
- R7: `underflow` is set by a frame boundary that finds no complete pair and then stays high until reset. The frame directly after reset is always idle, and only the boundary at its end can set the flag.
- R8: `blkStart` (`blkEnd`) is high for the whole frame whose pair contains a sample that was written with `inSop` (`inEop`) high. Both are low in idle frames.
- R9: A synchronous reset empties both FIFOs, clears `underflow`, `serEn`, `blkStart` and `blkEnd`, and restarts the frame counter at clock 0.
- R10: Each channel FIFO holds exactly 2^LOG_DEPTH samples. With no playback, that channel's `inReady` drops after that many accepted beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Addressed channel can accept a beat |
| inSample | input | 24 | Audio sample |
| inChan | input | 1 | Channel tag, 0 = first, 1 = second |
| inSop | input | 1 | Start of packet for this channel |
| inEop | input | 1 | End of packet for this channel |
| inValidBit | input | 1 | Validity bit of the sample |
| inUserBit | input | 1 | User bit of the sample |
| inStatusBit | input | 1 | Channel-status bit of the sample |
| serEn | output | 1 | Frame carries a real pair |
| serWs | output | 1 | Word select, high for first-channel half |
| serData | output | 1 | Serial data bit |
| blkStart | output | 1 | Current frame holds a start-marked sample |
| blkEnd | output | 1 | Current frame holds an end-marked sample |
| underflow | output | 1 | Sticky: a boundary found no full pair |

## Verification
A FIFO pointer or count that goes wrong shows up at the next frame boundary. It appears as a wrong `inReady` in the same cycle, a pair played out of order or one frame early or late, or an enable raised for a missing pair. A slip in the frame counter shows at once as `serWs` toggling on the wrong clock. A wrong bit order or parity shows in the first played frame, within 32 clocks of the frame start. Because every output is compared against a behavioural model on every clock, each fault is reported in the cycle it first becomes visible.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int SAMPLE_W    = 24;
  localparam int HALF_CLKS   = 32;
  localparam int FRAME_CLKS  = 2 * HALF_CLKS;
  localparam int SLOT_IDX_W  = $clog2(HALF_CLKS);
  localparam int FRAME_IDX_W = $clog2(FRAME_CLKS);
  localparam int NUM_CH      = 2;

  typedef struct packed {
    logic [SAMPLE_W-1:0] pcm;
    logic                vBit;
    logic                uBit;
    logic                cBit;
    logic                sop;
    logic                eop;
  } beat_t;

  localparam int BEAT_W = $bits(beat_t);

  typedef struct packed {
    logic loadPair;
    logic clearPair;
  } strobe_t;
endpackage

// File: rtl/sf_fifo.sv
module sf_fifo #(
  parameter int WIDTH     = 29,
  parameter int LOG_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int DEPTH = 1 << LOG_DEPTH;
  localparam int CNT_W = LOG_DEPTH + 1;

  logic [WIDTH-1:0]     mem [DEPTH];
  logic [LOG_DEPTH-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0]     count;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= wrPtr + 1'b1;
      if (rdEn) rdPtr <= rdPtr + 1'b1;
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) wrEn |-> !full)
    else $error("write into full FIFO");
  // R6
  no_underread_chk: assert property (@(posedge clk) disable iff (rst) rdEn |-> !empty)
    else $error("read from empty FIFO");
endmodule

// File: rtl/sf_datapath.sv
module sf_datapath
  import sf_pkg::*;
#(
  parameter int LOG_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  input  logic                   inChan,
  input  beat_t                  inBeat,
  input  strobe_t                strobe,
  input  logic [FRAME_IDX_W-1:0] slotIdx,
  output logic                   inReady,
  output logic                   pairReady,
  output logic                   serData,
  output logic                   blkStart,
  output logic                   blkEnd
);
  localparam logic [SLOT_IDX_W-1:0] MSB_IDX = SLOT_IDX_W'(SAMPLE_W - 1);
  localparam logic [SLOT_IDX_W-1:0] V_POS   = SLOT_IDX_W'(SAMPLE_W);
  localparam logic [SLOT_IDX_W-1:0] U_POS   = SLOT_IDX_W'(SAMPLE_W + 1);
  localparam logic [SLOT_IDX_W-1:0] C_POS   = SLOT_IDX_W'(SAMPLE_W + 2);
  localparam logic [SLOT_IDX_W-1:0] P_POS   = SLOT_IDX_W'(SAMPLE_W + 3);

  logic [NUM_CH-1:0] fullV, emptyV, wrEn;
  logic [BEAT_W-1:0] headBits [NUM_CH];
  logic              acceptBeat;
  beat_t             slotWord [NUM_CH];
  beat_t             cur;
  logic [SLOT_IDX_W-1:0] bitIdx;

  assign inReady    = !fullV[inChan];
  assign acceptBeat = inValid && inReady;
  assign pairReady  = !(|emptyV);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign wrEn[ch] = acceptBeat && (inChan == 1'(ch));
    sf_fifo #(.WIDTH(BEAT_W), .LOG_DEPTH(LOG_DEPTH)) i_fifo (
      .clk    (clk),
      .rst    (rst),
      .wrEn   (wrEn[ch]),
      .wrData (inBeat),
      .rdEn   (strobe.loadPair),
      .rdData (headBits[ch]),
      .full   (fullV[ch]),
      .empty  (emptyV[ch])
    );
  end

  always_ff @(posedge clk) begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (rst || strobe.clearPair) slotWord[ch] <= '0;
      else if (strobe.loadPair)    slotWord[ch] <= beat_t'(headBits[ch]);
    end
  end

  always_comb begin
    cur     = slotWord[slotIdx[FRAME_IDX_W-1]];
    bitIdx  = slotIdx[SLOT_IDX_W-1:0];
    serData = 1'b0;
    if (bitIdx <= MSB_IDX)     serData = cur.pcm[MSB_IDX - bitIdx];
    else if (bitIdx == V_POS)  serData = cur.vBit;
    else if (bitIdx == U_POS)  serData = cur.uBit;
    else if (bitIdx == C_POS)  serData = cur.cBit;
    else if (bitIdx == P_POS)  serData = ^{cur.pcm, cur.vBit, cur.uBit, cur.cBit};
  end

  assign blkStart = slotWord[0].sop | slotWord[1].sop;
  assign blkEnd   = slotWord[0].eop | slotWord[1].eop;
endmodule

// File: rtl/sf_ctrl.sv
module sf_ctrl
  import sf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pairReady,
  output strobe_t                strobe,
  output logic [FRAME_IDX_W-1:0] slotIdx,
  output logic                   serWs,
  output logic                   serEn,
  output logic                   underflow
);
  localparam logic [FRAME_IDX_W-1:0] LAST_CLK = FRAME_IDX_W'(FRAME_CLKS - 1);

  logic [FRAME_IDX_W-1:0] cnt;
  logic                   frameEnd;

  assign frameEnd         = (cnt == LAST_CLK);
  assign strobe.loadPair  = frameEnd && pairReady;
  assign strobe.clearPair = frameEnd && !pairReady;
  assign slotIdx          = cnt;
  assign serWs            = !cnt[FRAME_IDX_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      serEn     <= 1'b0;
      underflow <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (frameEnd) serEn <= pairReady;
      if (strobe.clearPair) underflow <= 1'b1;
    end
  end

  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst) underflow |=> underflow)
    else $error("underflow flag dropped");
endmodule

// File: rtl/stereo_serial_formatter.sv
module stereo_serial_formatter
  import sf_pkg::*;
#(
  parameter int LOG_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                inChan,
  input  logic                inSop,
  input  logic                inEop,
  input  logic                inValidBit,
  input  logic                inUserBit,
  input  logic                inStatusBit,
  output logic                serEn,
  output logic                serWs,
  output logic                serData,
  output logic                blkStart,
  output logic                blkEnd,
  output logic                underflow
);
  beat_t                  inBeat;
  strobe_t                strobe;
  logic [FRAME_IDX_W-1:0] slotIdx;
  logic                   pairReady;

  assign inBeat = '{pcm: inSample, vBit: inValidBit, uBit: inUserBit,
                    cBit: inStatusBit, sop: inSop, eop: inEop};

  sf_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pairReady (pairReady),
    .strobe    (strobe),
    .slotIdx   (slotIdx),
    .serWs     (serWs),
    .serEn     (serEn),
    .underflow (underflow)
  );

  sf_datapath #(.LOG_DEPTH(LOG_DEPTH)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inChan    (inChan),
    .inBeat    (inBeat),
    .strobe    (strobe),
    .slotIdx   (slotIdx),
    .inReady   (inReady),
    .pairReady (pairReady),
    .serData   (serData),
    .blkStart  (blkStart),
    .blkEnd    (blkEnd)
  );

  // R6
  idle_frame_quiet_chk: assert property (@(posedge clk) disable iff (rst) !serEn |-> !serData)
    else $error("data in idle frame");
  // R6
  pair_starts_at_ws_high_chk: assert property (@(posedge clk) disable iff (rst) $rose(serEn) |-> serWs)
    else $error("pair started mid-frame");
endmodule

// File: tb/test_stereo_serial_formatter.sv
module test_stereo_serial_formatter;
  localparam int LOG_DEPTH = 4;
  localparam int DEPTH = 1 << LOG_DEPTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inChan = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic inValidBit = 1'b0, inUserBit = 1'b0, inStatusBit = 1'b0;
  logic [23:0] inSample = '0;
  logic inReady, serEn, serWs, serData, blkStart, blkEnd, underflow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 1'b0;

  // model state: word = {pcm[23:0], v, u, c, sop, eop}
  logic [28:0] q0[$];
  logic [28:0] q1[$];
  logic [28:0] w0 = '0, w1 = '0;
  int  ph = 0;
  bit  act = 1'b0, uf = 1'b0;
  bit  okPair, rdy;

  always #10 clk = ~clk;

  stereo_serial_formatter #(.LOG_DEPTH(LOG_DEPTH)) i_stereo_serial_formatter (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inSample(inSample),
    .inChan(inChan), .inSop(inSop), .inEop(inEop), .inValidBit(inValidBit),
    .inUserBit(inUserBit), .inStatusBit(inStatusBit), .serEn(serEn), .serWs(serWs),
    .serData(serData), .blkStart(blkStart), .blkEnd(blkEnd), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string what, input int a, input int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d actual=%0d expected=%0d", what, cyc, a, e);
    end
  endtask

  function automatic logic bitOf(input logic [28:0] w, input int b);
    if (b < 24) return w[28-b];
    if (b == 24) return w[4];
    if (b == 25) return w[3];
    if (b == 26) return w[2];
    if (b == 27) return ^w[28:2];
    return 1'b0;
  endfunction

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      q0.delete(); q1.delete();
      ph = 0; act = 0; uf = 0; w0 = '0; w1 = '0;
      started = 1'b1;
    end else if (started) begin
      okPair = (q0.size() > 0) && (q1.size() > 0);
      rdy = inChan ? (q1.size() < DEPTH) : (q0.size() < DEPTH);
      if (ph == 63) begin
        if (okPair) begin
          w0 = q0.pop_front(); w1 = q1.pop_front(); act = 1'b1;
        end else begin
          w0 = '0; w1 = '0; act = 1'b0; uf = 1'b1;
        end
      end
      if (inValid && rdy) begin
        if (inChan) q1.push_back({inSample, inValidBit, inUserBit, inStatusBit, inSop, inEop});
        else        q0.push_back({inSample, inValidBit, inUserBit, inStatusBit, inSop, inEop});
      end
      ph = (ph + 1) % 64;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started) begin
      logic expRdy, expData;
      expRdy  = inChan ? (q1.size() < DEPTH) : (q0.size() < DEPTH);
      expData = act ? bitOf((ph < 32) ? w0 : w1, ph % 32) : 1'b0;
      chk(inReady == expRdy, "R1 R10 inReady", inReady, expRdy);
      chk(serWs == (ph < 32), "R3 serWs", serWs, (ph < 32));
      chk(serEn == act, "R6 serEn", serEn, act);
      chk(serData == expData, "R2 R4 R5 serData", serData, expData);
      chk(underflow == uf, "R7 underflow", underflow, uf);
      chk(blkStart == (w0[1] | w1[1]), "R8 blkStart", blkStart, w0[1] | w1[1]);
      chk(blkEnd == (w0[0] | w1[0]), "R8 blkEnd", blkEnd, w0[0] | w1[0]);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input bit ch, input logic [23:0] s, input bit v, input bit u,
                      input bit c, input bit sp, input bit ep);
    @(posedge clk); #1;
    inValid = 1'b1; inChan = ch; inSample = s;
    inValidBit = v; inUserBit = u; inStatusBit = c; inSop = sp; inEop = ep;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic doReset();
    @(posedge clk); #1; rst = 1'b1; inValid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9: state after synchronous reset
    chk(serEn == 1'b0, "R9 serEn after reset", serEn, 0);
    chk(underflow == 1'b0, "R9 underflow after reset", underflow, 0);
    chk(serWs == 1'b1, "R9 serWs after reset", serWs, 1);
    chk(inReady == 1'b1, "R9 inReady after reset", inReady, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(serEn == 1'b0 && serWs == 1'b1, "R9 reset state", serEn, 0);

    // four pairs with packet marks, then run dry
    for (int i = 0; i < 4; i++) begin
      send(1'b0, 24'hA00000 + 24'(i * 24'h1357), i[0], i[1], 1'b1, i == 0, i == 3);
      send(1'b1, 24'h5F0F0F ^ 24'(i * 24'h0F11), !i[0], 1'b0, i[1], i == 0, i == 3);
    end
    idle(64 * 7);
    @(negedge clk);
    chk(underflow == 1'b1, "R7 underflow after running dry", underflow, 1);

    // fill one channel to its depth, then the other
    doReset();
    for (int i = 0; i < DEPTH + 2; i++) send(1'b0, 24'(i * 24'h010203 + 7), 1'b0, i[0], 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1 inValid = 1'b0; inChan = 1'b0;
    @(negedge clk);
    chk(inReady == 1'b0, "R10 first channel full after DEPTH beats", inReady, 0);
    @(posedge clk); #1 inChan = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1, "R1 second channel ready while first full", inReady, 1);
    for (int i = 0; i < DEPTH; i++) send(1'b1, 24'hFFFFFF - 24'(i), i[1], 1'b1, i[0], 1'b0, i == DEPTH - 1);
    idle(64 * (DEPTH + 2));

    // random interleaving with random validity
    doReset();
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); #1;
      inValid = ($urandom % 4) == 0;
      inChan = 1'($urandom);
      inSample = 24'($urandom);
      inValidBit = 1'($urandom); inUserBit = 1'($urandom); inStatusBit = 1'($urandom);
      inSop = ($urandom % 8) == 0; inEop = ($urandom % 8) == 0;
    end
    idle(64 * 20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule